// File: doc/BRIEF.md
# Interleaved Edge-Triggered Coarse Delay Channel

One channel of a programmable timing generator, clocked by the fast (nominally 800 MHz) clock. Two event inputs, A and B, are sampled only in cycles where a half-rate phase enable is high. A low-to-high transition on either input is an event. Each event captures its own 10-bit time-set word. The top three bits of that word give a coarse delay in fast-clock cycles. The bottom seven bits are a fine code handed to an external fine vernier.

Each accepted event produces an active-low output pulse of fixed width. The pulse appears a fixed two cycles plus the coarse count after the sampling edge that detected the event. The fine code is presented with the pulse and is held until the next pulse.

Events that come too soon after the previous accepted event are discarded. In half-span mode, words beyond the lower half of the range are clamped. Both conditions are recorded in sticky error flags.

Top module: `cdly_chan`

## Requirements
- R1: After an asynchronous reset, pulse_no_o is 1, fine_o is 0, and refire_err_o and range_err_o are both 0.
- R2: An event is a sampling edge (phase_en_i high) at which ev_a_i or ev_b_i is 1 while its value at the previous phase-enabled sample was 0. A level that stays high gives no further event. A high level seen only at edges where phase_en_i is low is never detected.
- R3: A and B rising at the same sampling edge form exactly one event.
- R4: For an accepted event at edge n, with word w sampled at n, the output pulse starts at edge n + 2 + w[9:7].
- R5: A pulse holds pulse_no_o low for PULSE_W (2) cycles. A pulse that starts while another is still low restarts the width, so the two merge into one longer low period.
- R6: fine_o takes w[6:0] at the edge where the pulse starts and holds that value until the next pulse start.
- R7: An event fewer than MIN_GAP (4) cycles after the previous accepted event is dropped and sets the sticky refire_err_o.
- R8: When full_span_i is 0, an accepted word above 0x1FF is replaced by 0x1FF (coarse 3, fine 0x7F) and sets the sticky range_err_o. When full_span_i is 1, no word is clamped and range_err_o is not set.
- R9: When two accepted events are due to start a pulse at the same edge, one pulse is produced, and it carries the fine code of the later event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_en_i | input | 1 | Half-rate sampling enable |
| full_span_i | input | 1 | 1 = full span, 0 = half span |
| ev_a_i | input | 1 | Event input A |
| ev_b_i | input | 1 | Event input B |
| tset_i | input | 10 | Time-set word: [9:7] coarse, [6:0] fine |
| pulse_no_o | output | 1 | Delayed event pulse, active low |
| fine_o | output | 7 | Fine code of the current pulse |
| refire_err_o | output | 1 | Sticky: an event was dropped for spacing |
| range_err_o | output | 1 | Sticky: a half-span word was clamped |

## Verification
The bench sweeps every coarse value. It also aims at the input-side corners: a level held across several samples, a glitch that is seen only at unenabled edges, simultaneous A and B, and a B edge two cycles after an A edge. A wrong sampler would emit extra or missing pulses in these cases. A missing refire guard would emit a second pulse and leave the error flag clear.

On the output side it lines up two events so that they mature in the same cycle, and two that mature one cycle apart. A delay line that let the older entry win would show the wrong fine code. One that did not restart the width would show a short low period.

The half-span clamp is tested at both 0x1FF and a word above it. Without the clamp, the second word would fire late and carry the wrong fine code.

// File: rtl/cdly_pkg.sv
package cdly_pkg;
  localparam int TSET_W_DEF   = 10;
  localparam int COARSE_W_DEF = 3;
  localparam int MIN_GAP_DEF  = 4;
  localparam int PULSE_W_DEF  = 2;
endpackage

// File: rtl/cdly_edge_sampler.sv
module cdly_edge_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phase_en_i,
  input  logic ev_a_i,
  input  logic ev_b_i,
  output logic hit_o
);
  logic a_s_q, b_s_q;

  // retiming flops double as the previous-sample reference
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_s_q <= 1'b0;
      b_s_q <= 1'b0;
    end else if (phase_en_i) begin
      a_s_q <= ev_a_i;
      b_s_q <= ev_b_i;
    end
  end

  assign hit_o = phase_en_i & ((ev_a_i & ~a_s_q) | (ev_b_i & ~b_s_q));
endmodule

// File: rtl/cdly_refire_guard.sv
module cdly_refire_guard #(
  parameter int MIN_GAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  output logic accept_o,
  output logic refire_err_o
);
  localparam int GW = $clog2(MIN_GAP + 1);
  localparam logic [GW-1:0] GAP = GW'(MIN_GAP);

  logic [GW-1:0] since_q;
  logic          err_q;

  assign accept_o = hit_i && (since_q >= GAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= GAP;
      err_q   <= 1'b0;
    end else begin
      if (accept_o)          since_q <= GW'(1);
      else if (since_q < GAP) since_q <= since_q + GW'(1);
      if (hit_i && !accept_o) err_q <= 1'b1;
    end
  end

  assign refire_err_o = err_q;
endmodule

// File: rtl/cdly_delay_line.sv
module cdly_delay_line #(
  parameter int COARSE_W = 3,
  parameter int FINE_W   = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [FINE_W-1:0]   fine_i,
  output logic                mature_o,
  output logic [FINE_W-1:0]   fine_o
);
  localparam int DEPTH = (1 << COARSE_W) + 1;

  logic [DEPTH-1:0] vld_q;
  logic [FINE_W-1:0] fine_q [DEPTH];

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    logic              nxt_v;
    logic [FINE_W-1:0] nxt_f;
    logic              hit_here;

    if (j == DEPTH - 1) begin : g_top
      assign nxt_v = 1'b0;
      assign nxt_f = '0;
    end else begin : g_mid
      assign nxt_v = vld_q[j+1];
      assign nxt_f = fine_q[j+1];
    end

    assign hit_here = load_i && ((int'(coarse_i) + 1) == j);

    // a new entry overwrites an older one maturing in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[j]  <= 1'b0;
        fine_q[j] <= '0;
      end else if (hit_here) begin
        vld_q[j]  <= 1'b1;
        fine_q[j] <= fine_i;
      end else begin
        vld_q[j]  <= nxt_v;
        fine_q[j] <= nxt_f;
      end
    end
  end

  assign mature_o = vld_q[0];
  assign fine_o   = fine_q[0];
endmodule

// File: rtl/cdly_pulse_shaper.sv
module cdly_pulse_shaper #(
  parameter int FINE_W  = 7,
  parameter int PULSE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mature_i,
  input  logic [FINE_W-1:0] fine_i,
  output logic              pulse_no_o,
  output logic [FINE_W-1:0] fine_o
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [CW-1:0]     cnt_q;
  logic [FINE_W-1:0] fine_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      fine_q <= '0;
    end else if (mature_i) begin
      cnt_q  <= CW'(PULSE_W);
      fine_q <= fine_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign pulse_no_o = (cnt_q == '0);
  assign fine_o     = fine_q;
endmodule

// File: rtl/cdly_chan.sv
module cdly_chan #(
  parameter int TSET_W   = cdly_pkg::TSET_W_DEF,
  parameter int COARSE_W = cdly_pkg::COARSE_W_DEF,
  parameter int MIN_GAP  = cdly_pkg::MIN_GAP_DEF,
  parameter int PULSE_W  = cdly_pkg::PULSE_W_DEF,
  localparam int FINE_W  = TSET_W - COARSE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              phase_en_i,
  input  logic              full_span_i,
  input  logic              ev_a_i,
  input  logic              ev_b_i,
  input  logic [TSET_W-1:0] tset_i,
  output logic              pulse_no_o,
  output logic [FINE_W-1:0] fine_o,
  output logic              refire_err_o,
  output logic              range_err_o
);
  localparam logic [TSET_W-1:0] HALF_MAX = {1'b0, {(TSET_W-1){1'b1}}};

  logic hit, accept, over, range_q, mature;
  logic [TSET_W-1:0] word;
  logic [FINE_W-1:0] mat_fine;

  cdly_edge_sampler u_samp (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_en_i(phase_en_i),
    .ev_a_i(ev_a_i), .ev_b_i(ev_b_i), .hit_o(hit)
  );

  cdly_refire_guard #(.MIN_GAP(MIN_GAP)) u_guard (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit),
    .accept_o(accept), .refire_err_o(refire_err_o)
  );

  assign over = !full_span_i && tset_i[TSET_W-1];
  assign word = over ? HALF_MAX : tset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              range_q <= 1'b0;
    else if (accept && over)  range_q <= 1'b1;
  end
  assign range_err_o = range_q;

  cdly_delay_line #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_line (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept),
    .coarse_i(word[TSET_W-1 -: COARSE_W]), .fine_i(word[FINE_W-1:0]),
    .mature_o(mature), .fine_o(mat_fine)
  );

  cdly_pulse_shaper #(.FINE_W(FINE_W), .PULSE_W(PULSE_W)) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .mature_i(mature), .fine_i(mat_fine),
    .pulse_no_o(pulse_no_o), .fine_o(fine_o)
  );
endmodule

// File: rtl/cdly_chan_chk.sv
module cdly_chan_chk #(
  parameter int FINE_W = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_span_i,
  input logic              pulse_no_o,
  input logic [FINE_W-1:0] fine_o,
  input logic              refire_err_o,
  input logic              range_err_o
);
  assert_refire_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refire_err_o |=> refire_err_o);

  assert_range_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_err_o |=> range_err_o);

  assert_full_span_no_clamp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_span_i && !range_err_o) |=> !range_err_o);

  assert_fine_moves_with_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fine_o) |-> !pulse_no_o);

  assert_pulse_min_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pulse_no_o) |=> !pulse_no_o);
endmodule

bind cdly_chan cdly_chan_chk #(.FINE_W(FINE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .full_span_i(full_span_i),
  .pulse_no_o(pulse_no_o), .fine_o(fine_o),
  .refire_err_o(refire_err_o), .range_err_o(range_err_o)
);

// File: tb/cdly_chan_bench.sv
module cdly_chan_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic phase_en = 1'b0, full_span = 1'b1, ev_a = 1'b0, ev_b = 1'b0;
  logic [9:0] tset = '0;
  logic pulse_no, refire_err, range_err;
  logic [6:0] fine;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cdly_chan u_cdly_chan (
    .clk_i(clk), .rst_ni(rst_ni), .phase_en_i(phase_en), .full_span_i(full_span),
    .ev_a_i(ev_a), .ev_b_i(ev_b), .tset_i(tset), .pulse_no_o(pulse_no),
    .fine_o(fine), .refire_err_o(refire_err), .range_err_o(range_err)
  );

  // behavioural reference model
  int cyc = 0;
  int last_acc = -1000, last_fire = -1000;
  bit m_pa = 0, m_pb = 0, m_ref = 0, m_rng = 0;
  logic [6:0] m_fine = '0;
  bit         due [int];
  logic [6:0] due_fine [int];

  always @(posedge clk) begin
    if (!rst_ni) begin
      last_acc = -1000; last_fire = -1000;
      m_pa = 0; m_pb = 0; m_ref = 0; m_rng = 0; m_fine = '0;
    end else begin
      if (due.exists(cyc)) begin
        last_fire = cyc;
        m_fine = due_fine[cyc];
      end
      if (phase_en) begin
        bit rise;
        rise = (ev_a && !m_pa) || (ev_b && !m_pb);
        m_pa = ev_a; m_pb = ev_b;
        if (rise) begin
          if (cyc - last_acc < 4) m_ref = 1;
          else begin
            logic [9:0] w;
            int f;
            w = tset;
            last_acc = cyc;
            if (!full_span && w > 10'h1FF) begin w = 10'h1FF; m_rng = 1; end
            f = cyc + 2 + int'(w[9:7]);
            due[f] = 1;
            due_fine[f] = w[6:0];
          end
        end
      end
    end
    cyc++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h cyc=%0d", tag, act, exp, cyc);
    end
  endtask

  int starts = 0, lows = 0;
  logic prev_pn = 1'b1;
  always @(negedge clk) begin
    bit exp_pn;
    exp_pn = !((cyc - 1) - last_fire < 2);
    chk(pulse_no == exp_pn, "R4/R5 pulse timing", pulse_no, exp_pn);
    chk(fine == m_fine, "R6 fine code", fine, m_fine);
    chk(refire_err == m_ref, "R7 refire flag", refire_err, m_ref);
    chk(range_err == m_rng, "R8 range flag", range_err, m_rng);
    if (!pulse_no) lows++;
    if (prev_pn && !pulse_no) starts++;
    prev_pn = pulse_no;
  end

  task automatic step();
    @(negedge clk);
    phase_en = ~phase_en;
  endtask

  task automatic to_sample();
    do step(); while (!phase_en);
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic fire(input logic a, input logic b, input logic [9:0] w);
    to_sample();
    ev_a = a; ev_b = b; tset = w;
    step(); step();
    ev_a = 0; ev_b = 0;
  endtask

  initial begin
    int s0, l0;
    repeat (3) @(negedge clk);
    chk(pulse_no === 1'b1 && fine === 7'h0 && refire_err === 1'b0 && range_err === 1'b0,
        "R1 reset state", {pulse_no, fine, refire_err, range_err}, 10'h200);
    rst_ni = 1'b1;
    idle(4);

    for (int c = 0; c < 8; c++) begin
      s0 = starts; l0 = lows;
      if (c % 2 == 0) fire(1, 0, {c[2:0], 7'(c * 13 + 3)});
      else            fire(0, 1, {c[2:0], 7'(c * 13 + 3)});
      idle(14);
      chk(starts == s0 + 1, "R4 one pulse per coarse value", starts - s0, 1);
      chk(lows == l0 + 2, "R5 pulse width", lows - l0, 2);
      chk(fine == 7'(c * 13 + 3), "R6 fine after pulse", fine, c * 13 + 3);
    end

    // held A level, then B rises while A still high
    s0 = starts;
    to_sample(); ev_a = 1; tset = {3'd2, 7'h05};
    idle(8);
    to_sample(); ev_b = 1; tset = {3'd1, 7'h06};
    idle(4); ev_a = 0; ev_b = 0;
    idle(14);
    chk(starts == s0 + 2, "R2 held level gives no extra event", starts - s0, 2);

    // glitch visible only at an unenabled edge
    s0 = starts;
    do step(); while (phase_en);
    ev_a = 1; tset = 10'h0AA;
    step(); ev_a = 0;
    idle(14);
    chk(starts == s0, "R2 unsampled glitch ignored", starts - s0, 0);

    // A and B together
    s0 = starts;
    fire(1, 1, {3'd5, 7'h2C});
    idle(14);
    chk(starts == s0 + 1, "R3 simultaneous A/B single event", starts - s0, 1);

    // B two cycles after A: dropped
    s0 = starts;
    to_sample(); ev_a = 1; tset = {3'd0, 7'h3D};
    step(); step();
    ev_b = 1; tset = {3'd0, 7'h4E};
    step(); step(); ev_a = 0; ev_b = 0;
    idle(14);
    chk(starts == s0 + 1, "R7 close event dropped", starts - s0, 1);
    chk(refire_err == 1'b1, "R7 refire flag set", refire_err, 1);
    chk(fine == 7'h3D, "R7 surviving fine", fine, 7'h3D);

    // half span
    full_span = 0;
    fire(1, 0, 10'h1FF); idle(14);
    chk(range_err == 1'b0, "R8 0x1FF in range", range_err, 0);
    chk(fine == 7'h7F, "R8 0x1FF fine", fine, 7'h7F);
    fire(1, 0, 10'h02B); idle(14);
    fire(1, 0, 10'h3AB); idle(14);
    chk(range_err == 1'b1, "R8 clamp flag", range_err, 1);
    chk(fine == 7'h7F, "R8 clamped fine", fine, 7'h7F);
    full_span = 1;

    // same maturity cycle: later fine wins
    s0 = starts;
    to_sample(); ev_a = 1; tset = {3'd7, 7'h11};
    step(); step(); ev_a = 0; step(); step();
    ev_b = 1; tset = {3'd3, 7'h22};
    step(); step(); ev_b = 0;
    idle(14);
    chk(starts == s0 + 1, "R9 coincident maturity one pulse", starts - s0, 1);
    chk(fine == 7'h22, "R9 later fine wins", fine, 7'h22);

    // maturity one cycle apart: widths merge
    s0 = starts; l0 = lows;
    to_sample(); ev_a = 1; tset = {3'd7, 7'h31};
    step(); step(); ev_a = 0; step(); step();
    ev_b = 1; tset = {3'd4, 7'h33};
    step(); step(); ev_b = 0;
    idle(14);
    chk(starts == s0 + 1, "R5 merged pulse count", starts - s0, 1);
    chk(lows == l0 + 3, "R5 merged low length", lows - l0, 3);
    chk(fine == 7'h33, "R6 fine of second event", fine, 7'h33);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule